// File: doc/BRIEF.md
# Oversampled Quad-Lane Serial Target Front End

This block is the pin-facing half of a quad-lane SPI target that lives entirely in a fast logic clock. Nothing in it is clocked by the serial clock. Chip select, the serial clock and the four input data lanes arrive from an asynchronous controller. They pass through plain flip-flop synchronisers and are then treated as ordinary data. The synchronised serial clock is edge-detected in the logic domain:

- On each rising edge, a nibble is shifted in from the input lanes.
- On each falling edge, the next nibble is placed on the output lanes.

Toward the core, the block offers a one-cycle receive strobe carrying a whole byte. It also offers a load strobe that tells the core the byte on `tx_data` has been taken and the next one may be presented. Command decoding and anything beyond moving bytes sit outside.

Transfers are guaranteed when each serial clock phase, high or low, lasts at least five logic cycles. The synchroniser view of the pins lags by two to three cycles, and every capture and launch point is placed so that this lag, plus one extra cycle of metastability resolution, still falls inside the controller's timing windows.

Top module: `qspi_tgt_phy`

## Requirements
- R1: Every pin input passes through a two-stage synchroniser; when chip select falls at the pins, `spi_sd_oe` rises on the third rising clock edge after the change and not earlier.
- R2: While `rst_n` is low, `spi_sd_oe`, `rx_valid`, `tx_load` and `spi_sd_o` are all 0 whatever the pins do, and on the first clock edge after release the block is still deselected (`spi_sd_oe` stays 0).
- R3: Input nibbles are captured on synchronised serial clock rising edges, with `spi_sd_i[3]` as the nibble's most significant bit; the first nibble of a byte becomes `rx_data[7:4]` and the second `rx_data[3:0]`.
- R4: `rx_valid` is a strobe exactly one cycle wide, raised once per completed byte, after the second rising edge of that byte.
- R5: Capture is correct when input data is stable only from one cycle before a rising edge until three cycles after it, with other values on the lanes outside that window.
- R6: Transfers are correct for any serial clock whose high and low phases each last at least five logic cycles, including unequal high and low phases.
- R7: On a synchronised chip select falling edge, `tx_load` pulses for one cycle, `spi_sd_oe` goes to 1 and `tx_data[7:4]` is driven on `spi_sd_o`, valid at the first rising edge when that edge comes at least five cycles after chip select falls.
- R8: Each synchronised serial clock falling edge presents the next output nibble: after a high nibble it presents the low nibble of the same byte; after a low nibble it pulses `tx_load` and presents the high nibble of the new `tx_data`; each nibble is valid at the following rising edge.
- R9: On a synchronised chip select rising edge, a partial byte is dropped without `rx_valid`, and `spi_sd_oe` falls on the third clock edge after the pin rises.
- R10: A new selection restarts nibble counting in both directions, so the first byte after a partial frame is received and sent whole and aligned.
- R11: Serial clock edges while chip select is high are ignored: no `rx_valid`, no `tx_load` and `spi_sd_oe` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Logic clock; all state is clocked by it |
| rst_n | input | 1 | Asynchronous active-low reset, holds the block deselected |
| spi_cs_n | input | 1 | Chip select pin from the controller, active low, asynchronous |
| spi_sck | input | 1 | Serial clock pin, idles low, asynchronous |
| spi_sd_i | input | LANES (4) | Input data lanes from the controller |
| spi_sd_o | output | LANES (4) | Output data lanes toward the controller |
| spi_sd_oe | output | 1 | Output enable for the data lanes, 1 while selected |
| rx_valid | output | 1 | One-cycle strobe: `rx_data` holds a received byte |
| rx_data | output | WORD_W (8) | Received byte, first nibble in the upper bits |
| tx_data | input | WORD_W (8) | Next byte to transmit, taken when `tx_load` pulses |
| tx_load | output | 1 | One-cycle strobe: `tx_data` was taken, present the next byte |

## Verification
The bench builds the block with its defaults: four lanes, eight-bit words and two synchroniser stages. Each byte is therefore two nibbles, and both nibble counters roll over at every byte boundary. Chip select edges surface exactly three logic edges after the pins change, so that latency can be counted cycle by cycle. The controller model runs phases down to the five-cycle minimum and narrows the input data window to its guaranteed limits. This puts the tightest capture and launch points within reach at these parameter values.

// File: rtl/qspi_tgt_pkg.sv
package qspi_tgt_pkg;

    // Width of a counter that must hold values 0 .. n-1 (at least one bit).
    function automatic int cnt_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // A pair of edge pulses derived from one synchronised pin.
    typedef struct packed {
        logic rise;
        logic fall;
    } edge_pair_t;

endpackage

// File: rtl/qspi_tgt_sync.sv
module qspi_tgt_sync #(
    parameter int              W       = 1,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    typedef struct packed {
        logic [STAGES-1:0][W-1:0] stg;
    } sync_state_t;

    sync_state_t state_d, state_q;

    always_comb begin
        state_d.stg[0] = async_in;
        for (int i = 1; i < STAGES; i++) begin
            state_d.stg[i] = state_q.stg[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.stg <= {STAGES{RST_VAL}};
        end else begin
            state_q <= state_d;
        end
    end

    assign sync_out = state_q.stg[STAGES-1];

endmodule

// File: rtl/qspi_tgt_edge.sv
module qspi_tgt_edge
    import qspi_tgt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sck_s,
    input  logic       cs_n_s,
    output edge_pair_t sck_e,
    output edge_pair_t cs_e
);

    typedef struct packed {
        logic sck;
        logic cs_n;
    } edge_state_t;

    edge_state_t state_d, state_q;
    logic        held_sel;

    always_comb begin
        state_d.sck  = sck_s;
        state_d.cs_n = cs_n_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{sck: 1'b0, cs_n: 1'b1};
        end else begin
            state_q <= state_d;
        end
    end

    // Serial clock edges count only when selection was already in place on
    // the previous cycle, so they never coincide with a select edge.
    assign held_sel   = ~cs_n_s & ~state_q.cs_n;

    assign cs_e.fall  =  state_q.cs_n & ~cs_n_s;
    assign cs_e.rise  = ~state_q.cs_n &  cs_n_s;
    assign sck_e.rise =  sck_s & ~state_q.sck & held_sel;
    assign sck_e.fall = ~sck_s &  state_q.sck & held_sel;

endmodule

// File: rtl/qspi_tgt_rx.sv
module qspi_tgt_rx
    import qspi_tgt_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  edge_pair_t        sck_e,
    input  edge_pair_t        cs_e,
    input  logic [LANES-1:0]  nib_in,
    output logic              rx_valid,
    output logic [WORD_W-1:0] rx_data
);

    localparam int NIBS  = WORD_W / LANES;
    localparam int CNT_W = cnt_width(NIBS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(NIBS - 1);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] shreg;
        logic [WORD_W-1:0] data;
        logic              valid;
    } rx_state_t;

    rx_state_t         state_d, state_q;
    logic [WORD_W-1:0] merged;

    always_comb begin
        state_d       = state_q;
        state_d.valid = 1'b0;
        merged        = (state_q.shreg << LANES) | WORD_W'(nib_in);

        if (cs_e.fall || cs_e.rise) begin
            state_d.cnt   = '0;
            state_d.shreg = '0;
        end else if (sck_e.rise) begin
            state_d.shreg = merged;
            if (state_q.cnt == LAST) begin
                state_d.cnt   = '0;
                state_d.data  = merged;
                state_d.valid = 1'b1;
            end else begin
                state_d.cnt = state_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rx_valid = state_q.valid;
    assign rx_data  = state_q.data;

endmodule

// File: rtl/qspi_tgt_tx.sv
module qspi_tgt_tx
    import qspi_tgt_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  edge_pair_t        sck_e,
    input  edge_pair_t        cs_e,
    input  logic [WORD_W-1:0] tx_data,
    output logic              tx_load,
    output logic [LANES-1:0]  sd_out,
    output logic              sd_oe
);

    localparam int NIBS  = WORD_W / LANES;
    localparam int CNT_W = cnt_width(NIBS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(NIBS - 1);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] shreg;
        logic [LANES-1:0]  sd;
        logic              oe;
        logic              load;
    } tx_state_t;

    tx_state_t         state_d, state_q;
    logic [WORD_W-1:0] shifted;

    always_comb begin
        state_d      = state_q;
        state_d.load = 1'b0;
        shifted      = state_q.shreg << LANES;

        if (cs_e.rise) begin
            state_d.oe  = 1'b0;
            state_d.cnt = '0;
        end else if (cs_e.fall) begin
            state_d.shreg = tx_data;
            state_d.sd    = tx_data[WORD_W-1 -: LANES];
            state_d.cnt   = '0;
            state_d.oe    = 1'b1;
            state_d.load  = 1'b1;
        end else if (sck_e.fall) begin
            if (state_q.cnt == LAST) begin
                state_d.shreg = tx_data;
                state_d.sd    = tx_data[WORD_W-1 -: LANES];
                state_d.cnt   = '0;
                state_d.load  = 1'b1;
            end else begin
                state_d.shreg = shifted;
                state_d.sd    = shifted[WORD_W-1 -: LANES];
                state_d.cnt   = state_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign tx_load = state_q.load;
    assign sd_out  = state_q.sd;
    assign sd_oe   = state_q.oe;

endmodule

// File: rtl/qspi_tgt_phy.sv
module qspi_tgt_phy
    import qspi_tgt_pkg::*;
#(
    parameter int LANES       = 4,
    parameter int WORD_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_cs_n,
    input  logic              spi_sck,
    input  logic [LANES-1:0]  spi_sd_i,
    output logic [LANES-1:0]  spi_sd_o,
    output logic              spi_sd_oe,
    output logic              rx_valid,
    output logic [WORD_W-1:0] rx_data,
    input  logic [WORD_W-1:0] tx_data,
    output logic              tx_load
);

    localparam int SYNC_W = LANES + 2;
    localparam logic [SYNC_W-1:0] SYNC_RST = {1'b1, 1'b0, {LANES{1'b0}}};

    logic [SYNC_W-1:0] pins_sync;
    logic              cs_n_s;
    logic              sck_s;
    logic [LANES-1:0]  sd_s;
    edge_pair_t        sck_e;
    edge_pair_t        cs_e;

    // Chip select resets high and the clock low, so reset reads as idle.
    qspi_tgt_sync #(
        .W       (SYNC_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_RST)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({spi_cs_n, spi_sck, spi_sd_i}),
        .sync_out (pins_sync)
    );

    assign cs_n_s = pins_sync[SYNC_W-1];
    assign sck_s  = pins_sync[SYNC_W-2];
    assign sd_s   = pins_sync[LANES-1:0];

    qspi_tgt_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sck_s  (sck_s),
        .cs_n_s (cs_n_s),
        .sck_e  (sck_e),
        .cs_e   (cs_e)
    );

    qspi_tgt_rx #(
        .LANES  (LANES),
        .WORD_W (WORD_W)
    ) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck_e    (sck_e),
        .cs_e     (cs_e),
        .nib_in   (sd_s),
        .rx_valid (rx_valid),
        .rx_data  (rx_data)
    );

    qspi_tgt_tx #(
        .LANES  (LANES),
        .WORD_W (WORD_W)
    ) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .sck_e   (sck_e),
        .cs_e    (cs_e),
        .tx_data (tx_data),
        .tx_load (tx_load),
        .sd_out  (spi_sd_o),
        .sd_oe   (spi_sd_oe)
    );

endmodule

// File: rtl/qspi_tgt_phy_chk.sv
module qspi_tgt_phy_chk
    import qspi_tgt_pkg::*;
#(
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input edge_pair_t       sck_e,
    input edge_pair_t       cs_e,
    input logic             rx_valid,
    input logic             tx_load,
    input logic [LANES-1:0] spi_sd_o,
    input logic             spi_sd_oe
);

    // R4: the receive strobe is never wider than one cycle
    a_r4_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R4: a received byte is only reported right after a capture edge
    a_r4_strobe_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(sck_e.rise));

    // R7: selection loads a byte and enables the output lanes
    a_r7_select_loads: assert property (@(posedge clk) disable iff (!rst_n)
        cs_e.fall |=> (tx_load && spi_sd_oe));

    // R8: output lanes change only after a falling edge or a selection
    a_r8_launch_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(spi_sd_o) |-> $past(sck_e.fall || cs_e.fall));

    // R9: deselection disables the lanes and reports no partial byte
    a_r9_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cs_e.rise |=> (!spi_sd_oe && !rx_valid));

    // R11: no loads while the lanes are disabled and no selection is arriving
    a_r11_idle_no_load: assert property (@(posedge clk) disable iff (!rst_n)
        (!spi_sd_oe && !cs_e.fall) |=> !tx_load);

endmodule

bind qspi_tgt_phy qspi_tgt_phy_chk #(.LANES(LANES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sck_e     (sck_e),
    .cs_e      (cs_e),
    .rx_valid  (rx_valid),
    .tx_load   (tx_load),
    .spi_sd_o  (spi_sd_o),
    .spi_sd_oe (spi_sd_oe)
);

// File: tb/qspi_tgt_phy_bench.sv
module qspi_tgt_phy_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spi_cs_n = 1'b1;
    logic       spi_sck = 1'b0;
    logic [3:0] spi_sd_i = 4'h0;
    logic [3:0] spi_sd_o;
    logic       spi_sd_oe;
    logic       rx_valid;
    logic [7:0] rx_data;
    logic [7:0] tx_data;
    logic       tx_load;

    int n_chk = 0;
    int n_err = 0;
    int tx_idx = 0;
    logic [7:0] rx_q[$];

    always #10 clk = ~clk;

    qspi_tgt_phy u_qspi_tgt_phy (
        .clk       (clk),
        .rst_n     (rst_n),
        .spi_cs_n  (spi_cs_n),
        .spi_sck   (spi_sck),
        .spi_sd_i  (spi_sd_i),
        .spi_sd_o  (spi_sd_o),
        .spi_sd_oe (spi_sd_oe),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .tx_data   (tx_data),
        .tx_load   (tx_load)
    );

    function automatic logic [7:0] txb(input int k);
        return 8'((k * 37 + 60) & 255);
    endfunction

    assign tx_data = txb(tx_idx);

    // Core-side model: collect bytes, advance the transmit byte on each load.
    always @(negedge clk) begin
        if (rx_valid) rx_q.push_back(rx_data);
        if (tx_load) tx_idx = tx_idx + 1;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One frame of nbytes, as a controller with given phase lengths drives it.
    task automatic run_frame(input string tag, input int nbytes, input int hi, input int lo,
                             input logic [7:0] seed, input bit tight);
        int idx0;
        logic [7:0] mosi;
        logic [7:0] miso;
        logic [3:0] nib;
        idx0 = tx_idx;
        rx_q.delete();
        @(negedge clk);
        spi_cs_n = 1'b0;
        for (int b = 0; b < nbytes; b++) begin
            mosi = 8'(seed + b * 107);
            miso = txb(idx0 + b);
            for (int n = 0; n < 2; n++) begin
                nib = (n == 0) ? mosi[7:4] : mosi[3:0];
                if (tight) begin
                    spi_sd_i = ~nib;
                    cyc(lo - 1);
                    spi_sd_i = nib;
                    cyc(1);
                end else begin
                    spi_sd_i = nib;
                    cyc(lo);
                end
                if (b == 0 && n == 0) begin
                    check({tag, " R7 oe at first edge"}, 32'(spi_sd_oe), 32'd1);
                    check({tag, " R7 load on select"}, 32'(tx_idx), 32'(idx0 + 1));
                end
                check({tag, " R8 output nibble"}, 32'(spi_sd_o),
                      32'((n == 0) ? miso[7:4] : miso[3:0]));
                spi_sck = 1'b1;
                if (tight) begin
                    cyc(3);
                    spi_sd_i = ~nib;
                    cyc(hi - 3);
                end else begin
                    cyc(hi);
                end
                spi_sck = 1'b0;
            end
        end
        cyc(lo);
        spi_cs_n = 1'b1;
        cyc(8);
        check({tag, " R4 byte count"}, 32'(rx_q.size()), 32'(nbytes));
        for (int b = 0; b < nbytes && b < rx_q.size(); b++) begin
            check({tag, " R3 received byte"}, 32'(rx_q[b]), 32'(8'(seed + b * 107)));
        end
        check({tag, " R8 loads per frame"}, 32'(tx_idx), 32'(idx0 + nbytes + 1));
        check({tag, " R9 oe off after frame"}, 32'(spi_sd_oe), 32'd0);
    endtask

    task automatic t_reset;
        spi_cs_n = 1'b0;
        for (int i = 0; i < 4; i++) begin
            spi_sck = ~spi_sck;
            spi_sd_i = 4'(i * 5);
            @(negedge clk);
            check("R2 oe in reset", 32'(spi_sd_oe), 32'd0);
            check("R2 strobes in reset", 32'({rx_valid, tx_load}), 32'd0);
        end
        check("R2 sd_o in reset", 32'(spi_sd_o), 32'd0);
        spi_sck = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 deselected after release", 32'(spi_sd_oe), 32'd0);
        spi_cs_n = 1'b1;
        cyc(8);
        check("R2 idle after release", 32'(spi_sd_oe), 32'd0);
        rx_q.delete();
    endtask

    task automatic t_latency;
        @(negedge clk);
        spi_cs_n = 1'b0;
        cyc(2);
        check("R1 oe not before third edge", 32'(spi_sd_oe), 32'd0);
        cyc(1);
        check("R1 oe at third edge", 32'(spi_sd_oe), 32'd1);
        cyc(4);
        spi_cs_n = 1'b1;
        cyc(2);
        check("R9 oe held two edges", 32'(spi_sd_oe), 32'd1);
        cyc(1);
        check("R9 oe off at third edge", 32'(spi_sd_oe), 32'd0);
        cyc(6);
    endtask

    task automatic t_partial;
        int idx0;
        idx0 = tx_idx;
        rx_q.delete();
        @(negedge clk);
        spi_cs_n = 1'b0;
        spi_sd_i = 4'h9;
        cyc(6);
        spi_sck = 1'b1;
        cyc(5);
        spi_sck = 1'b0;
        cyc(6);
        check("R8 low nibble after first fall", 32'(spi_sd_o), 32'(txb(idx0) & 8'h0F));
        spi_cs_n = 1'b1;
        cyc(8);
        check("R9 partial byte dropped", 32'(rx_q.size()), 32'd0);
        check("R9 oe off after partial", 32'(spi_sd_oe), 32'd0);
        check("R9 no load mid byte", 32'(tx_idx), 32'(idx0 + 1));
        run_frame("R10 after partial", 2, 5, 5, 8'h1E, 1'b0);
    endtask

    task automatic t_ignored;
        int idx0;
        idx0 = tx_idx;
        rx_q.delete();
        for (int i = 0; i < 8; i++) begin
            spi_sck = ~spi_sck;
            spi_sd_i = 4'(i);
            for (int c = 0; c < 5; c++) begin
                @(negedge clk);
                if (spi_sd_oe !== 1'b0)
                    check("R11 oe while deselected", 32'(spi_sd_oe), 32'd0);
            end
        end
        cyc(4);
        n_chk++;
        check("R11 no rx while deselected", 32'(rx_q.size()), 32'd0);
        check("R11 no load while deselected", 32'(tx_idx), 32'(idx0));
    endtask

    initial begin
        #(20 * 150000);
        n_err++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_latency();
        run_frame("R6 symmetric 5/5", 1, 5, 5, 8'hA5, 1'b0);
        run_frame("R6 asymmetric 5/7", 3, 5, 7, 8'h3C, 1'b0);
        run_frame("R6 slow 12/9", 2, 12, 9, 8'h71, 1'b0);
        run_frame("R5 tight window", 3, 5, 5, 8'hD2, 1'b1);
        t_partial();
        t_ignored();
        run_frame("R3 final", 2, 6, 6, 8'h0F, 1'b0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule